// File: doc/BRIEF.md
# I2C LCD command receiver

This block is the write-only serial front end of a segment LCD controller. It watches the two-wire bus lines, picks out transfers sent to its 7-bit address, and then reads a run of command bytes that set the display controls. Once a command byte arrives with its top bit clear, every later byte of the transfer is display data. Display bytes are passed, one at a time, to the RAM writer over a valid/accept handshake. Each byte carries a flag that says whether this device's hardware subaddress matches the current subaddress counter. Bytes that do not match are still passed on, so the writer can advance its pointer.

The receiver pulls SDA low to acknowledge. The address byte and every command byte are acknowledged whenever the address matches. A display byte is acknowledged only when the subaddress matches. If a display byte finishes while the previous one has not been accepted, the receiver holds SCL low until the writer takes the pending byte, so no byte is lost. Both bus lines pass through synchronizer flops, and the block detects bus edges, START and STOP conditions on the synchronized copies.

Top module: `lcd_cmd_rx`

## Requirements
- R1: The address byte is acknowledged only when its upper seven bits equal 0111000 with bit 1 replaced by `addr_sel`, and its lowest bit (transfer direction) is 0. A non-matching or read address is not acknowledged, and all later bytes of that transfer are neither acknowledged nor applied.
- R2: Bit 7 of each command byte is a continuation flag. With 1, the next byte is also a command. With 0, every following byte of the transfer is display data, even if it looks like a command. Command bytes are acknowledged.
- R3: A command with bits 6:5 = 10 sets `low_power` from bit 4, `display_on` from bit 3 and `bias_half` from bit 2, and sets `drive_mode` from bits 1:0 (00 static, 01 two-way, 10 three-way, 11 four-way).
- R4: A command with bit 6 = 0 pulses `ptr_load` for exactly one cycle, with `ptr_value` equal to bits 5:0.
- R5: A command with bits 6:3 = 1100 loads `sub_counter` from bits 2:0.
- R6: A command with bits 6:2 = 11110 sets `bank_in` from bit 1 and `bank_out` from bit 0.
- R7: A command with bits 6:3 = 1110 sets `blink_alt` from bit 2 and `blink_rate` from bits 1:0.
- R8: Every display byte appears on `wr_data` with `wr_valid`. `wr_mine` is set and the byte is acknowledged only when `sub_counter` equals `hw_sub`; otherwise the byte is not acknowledged.
- R9: When a display byte completes while `wr_valid` is still waiting for `wr_accept`, the block holds SCL low until the pending byte is accepted. While `wr_valid` waits, `wr_data` holds steady. No byte is lost or reordered.
- R10: A START condition (SDA falls while SCL is high) always restarts address reception, including inside a transfer. After a STOP condition (SDA rises while SCL is high), bus bits are ignored and not acknowledged until the next START.
- R11: After reset the block holds these values: `drive_mode` 11, `bias_half` 0, `display_on` 0, `low_power` 0, blink off with `blink_alt` 0, both bank bits 0, `sub_counter` 0, no pulls, `wr_valid` 0.
- R12: The SDA pull-down changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel | input | 1 | Selects address bit 1 |
| hw_sub | input | 3 | Hardware subaddress of this device |
| wr_accept | input | 1 | RAM writer takes the pending display byte |
| sda_pull_o | output | 1 | Pull SDA low (acknowledge) |
| scl_pull_o | output | 1 | Pull SCL low (clock stretch) |
| low_power | output | 1 | Power-saving mode bit |
| display_on | output | 1 | Display enable |
| bias_half | output | 1 | 1 = half bias, 0 = third bias |
| drive_mode | output | 2 | Backplane multiplex selection |
| sub_counter | output | 3 | Subaddress counter |
| bank_in | output | 1 | Input bank selection |
| bank_out | output | 1 | Output bank selection |
| blink_alt | output | 1 | Alternate-bank blink mode |
| blink_rate | output | 2 | Blink frequency code, 0 = off |
| ptr_load | output | 1 | One-cycle pulse: load data pointer |
| ptr_value | output | 6 | Data pointer value for `ptr_load` |
| wr_valid | output | 1 | Display byte pending |
| wr_data | output | 8 | Pending display byte |
| wr_mine | output | 1 | Pending byte matches this device's subaddress |

## Verification
The checker tests the handshake and bus-timing rules on every cycle. It checks that the SDA pull never changes while the synchronized SCL stays high, and that SCL is stretched only while a byte is pending. It also checks that a pending byte and its data stay put until accepted, that the pointer load is a single-cycle pulse, and that the two pulls are never active together. Address filtering, continuation-bit sequencing, the command field decode, subaddress-dependent acknowledge, and the effect of START and STOP can only be shown by the bench's bus transfers. The bench also checks the order of stretched display bytes through its scoreboard.

// File: rtl/lcd_rx_pkg.sv
package lcd_rx_pkg;

    localparam int BYTE_W = 8;
    localparam int PTR_W  = 6;
    localparam int SUB_W  = 3;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_DATA,
        ST_SKIP
    } rx_state_e;

    typedef enum logic [2:0] {
        CMD_PTR,
        CMD_MODE,
        CMD_DEV,
        CMD_BLINK,
        CMD_BANK,
        CMD_NONE
    } cmd_kind_e;

    typedef struct packed {
        logic             low_power;
        logic             display_on;
        logic             bias_half;
        logic [1:0]       drive_mode;
        logic [SUB_W-1:0] sub_counter;
        logic             bank_in;
        logic             bank_out;
        logic             blink_alt;
        logic [1:0]       blink_rate;
    } lcd_cfg_t;

    localparam lcd_cfg_t CFG_RESET = '{
        low_power:   1'b0,
        display_on:  1'b0,
        bias_half:   1'b0,
        drive_mode:  2'b11,
        sub_counter: '0,
        bank_in:     1'b0,
        bank_out:    1'b0,
        blink_alt:   1'b0,
        blink_rate:  2'b00
    };

    // Opcode fields sit in the seven bits below the continuation flag.
    function automatic cmd_kind_e classify(input logic [BYTE_W-2:0] b);
        if (!b[6])                  return CMD_PTR;
        else if (b[6:5] == 2'b10)   return CMD_MODE;
        else if (b[6:3] == 4'b1100) return CMD_DEV;
        else if (b[6:3] == 4'b1110) return CMD_BLINK;
        else if (b[6:2] == 5'b11110) return CMD_BANK;
        else                        return CMD_NONE;
    endfunction

endpackage

// File: rtl/lcd_rx_sync.sv
module lcd_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_cond,
    output logic stop_cond
);
    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_d;
    logic              sda_d;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_chain <= '1;
                    sda_chain <= '1;
                end else begin
                    scl_chain <= scl_i;
                    sda_chain <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_chain <= '1;
                    sda_chain <= '1;
                end else begin
                    scl_chain <= {scl_chain[STAGES-2:0], scl_i};
                    sda_chain <= {sda_chain[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_chain[STAGES-1];
            sda_d <= sda_chain[STAGES-1];
        end
    end

    assign scl_s      = scl_chain[STAGES-1];
    assign sda_s      = sda_chain[STAGES-1];
    assign scl_rise   = scl_s & ~scl_d;
    assign scl_fall   = ~scl_s & scl_d;
    assign start_cond = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_cond  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/lcd_rx_cmd.sv
module lcd_rx_cmd
    import lcd_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_strobe,
    input  logic [BYTE_W-2:0] cmd_bits,
    output lcd_cfg_t          cfg,
    output logic              ptr_load,
    output logic [PTR_W-1:0]  ptr_value
);
    cmd_kind_e kind;
    assign kind = classify(cmd_bits);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= CFG_RESET;
            ptr_load  <= 1'b0;
            ptr_value <= '0;
        end else begin
            ptr_load <= 1'b0;
            if (cmd_strobe) begin
                case (kind)
                    CMD_PTR: begin
                        ptr_load  <= 1'b1;
                        ptr_value <= cmd_bits[PTR_W-1:0];
                    end
                    CMD_MODE: begin
                        cfg.low_power  <= cmd_bits[4];
                        cfg.display_on <= cmd_bits[3];
                        cfg.bias_half  <= cmd_bits[2];
                        cfg.drive_mode <= cmd_bits[1:0];
                    end
                    CMD_DEV:   cfg.sub_counter <= cmd_bits[SUB_W-1:0];
                    CMD_BLINK: begin
                        cfg.blink_alt  <= cmd_bits[2];
                        cfg.blink_rate <= cmd_bits[1:0];
                    end
                    CMD_BANK: begin
                        cfg.bank_in  <= cmd_bits[1];
                        cfg.bank_out <= cmd_bits[0];
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/lcd_cmd_rx.sv
module lcd_cmd_rx
    import lcd_rx_pkg::*;
#(
    parameter logic [5:0] ADDR_PREFIX = 6'b011100,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_sel,
    input  logic [SUB_W-1:0]  hw_sub,
    input  logic              wr_accept,
    output logic              sda_pull_o,
    output logic              scl_pull_o,
    output logic              low_power,
    output logic              display_on,
    output logic              bias_half,
    output logic [1:0]        drive_mode,
    output logic [SUB_W-1:0]  sub_counter,
    output logic              bank_in,
    output logic              bank_out,
    output logic              blink_alt,
    output logic [1:0]        blink_rate,
    output logic              ptr_load,
    output logic [PTR_W-1:0]  ptr_value,
    output logic              wr_valid,
    output logic [BYTE_W-1:0] wr_data,
    output logic              wr_mine
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    logic scl_s, sda_s, scl_rise, scl_fall, start_cond, stop_cond;

    lcd_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_s      (scl_s),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_cond (start_cond),
        .stop_cond  (stop_cond)
    );

    rx_state_e         state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              ack_phase;
    logic              sda_pull;
    logic              stall;
    logic              cmd_strobe;
    lcd_cfg_t          cfg;
    logic              addr_hit;
    logic              mine;

    assign addr_hit = (shreg[BYTE_W-1:1] == {ADDR_PREFIX, addr_sel}) && !shreg[0];
    assign mine     = (cfg.sub_counter == hw_sub);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            bit_cnt    <= '0;
            shreg      <= '0;
            ack_phase  <= 1'b0;
            sda_pull   <= 1'b0;
            stall      <= 1'b0;
            cmd_strobe <= 1'b0;
            wr_valid   <= 1'b0;
            wr_data    <= '0;
            wr_mine    <= 1'b0;
        end else begin
            cmd_strobe <= 1'b0;
            if (wr_valid && wr_accept)
                wr_valid <= 1'b0;

            if (start_cond || stop_cond) begin
                state     <= start_cond ? ST_ADDR : ST_IDLE;
                bit_cnt   <= '0;
                ack_phase <= 1'b0;
                sda_pull  <= 1'b0;
                stall     <= 1'b0;
            end else if (stall) begin
                // SCL is held low here; release once the slot frees up.
                if (!wr_valid || wr_accept) begin
                    wr_valid  <= 1'b1;
                    wr_data   <= shreg;
                    wr_mine   <= mine;
                    stall     <= 1'b0;
                    ack_phase <= 1'b1;
                    sda_pull  <= mine;
                end
            end else if (state != ST_IDLE) begin
                if (scl_rise && !ack_phase && bit_cnt < LAST_BIT) begin
                    shreg   <= {shreg[BYTE_W-2:0], sda_s};
                    bit_cnt <= bit_cnt + 1'b1;
                end else if (scl_fall) begin
                    if (ack_phase) begin
                        ack_phase <= 1'b0;
                        sda_pull  <= 1'b0;
                        bit_cnt   <= '0;
                    end else if (bit_cnt == LAST_BIT) begin
                        case (state)
                            ST_ADDR: begin
                                if (addr_hit) begin
                                    state     <= ST_CMD;
                                    ack_phase <= 1'b1;
                                    sda_pull  <= 1'b1;
                                end else begin
                                    state   <= ST_SKIP;
                                    bit_cnt <= '0;
                                end
                            end
                            ST_CMD: begin
                                cmd_strobe <= 1'b1;
                                ack_phase  <= 1'b1;
                                sda_pull   <= 1'b1;
                                if (!shreg[BYTE_W-1])
                                    state <= ST_DATA;
                            end
                            ST_DATA: begin
                                if (wr_valid && !wr_accept) begin
                                    stall <= 1'b1;
                                end else begin
                                    wr_valid  <= 1'b1;
                                    wr_data   <= shreg;
                                    wr_mine   <= mine;
                                    ack_phase <= 1'b1;
                                    sda_pull  <= mine;
                                end
                            end
                            default: bit_cnt <= '0;
                        endcase
                    end
                end
            end
        end
    end

    lcd_rx_cmd u_cmd (
        .clk        (clk),
        .rst        (rst),
        .cmd_strobe (cmd_strobe),
        .cmd_bits   (shreg[BYTE_W-2:0]),
        .cfg        (cfg),
        .ptr_load   (ptr_load),
        .ptr_value  (ptr_value)
    );

    assign sda_pull_o  = sda_pull;
    assign scl_pull_o  = stall;
    assign low_power   = cfg.low_power;
    assign display_on  = cfg.display_on;
    assign bias_half   = cfg.bias_half;
    assign drive_mode  = cfg.drive_mode;
    assign sub_counter = cfg.sub_counter;
    assign bank_in     = cfg.bank_in;
    assign bank_out    = cfg.bank_out;
    assign blink_alt   = cfg.blink_alt;
    assign blink_rate  = cfg.blink_rate;
endmodule

// File: rtl/lcd_rx_chk.sv
module lcd_rx_chk
    import lcd_rx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              scl_s,
    input logic              sda_pull_o,
    input logic              scl_pull_o,
    input logic              wr_valid,
    input logic              wr_accept,
    input logic [BYTE_W-1:0] wr_data,
    input logic              ptr_load
);
    p_sda_steady_r12: assert property (@(posedge clk) disable iff (rst)
        (scl_s && $past(scl_s)) |-> $stable(sda_pull_o));

    p_stretch_pending_r9: assert property (@(posedge clk) disable iff (rst)
        scl_pull_o |-> wr_valid);

    p_hold_data_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_accept) |=> (wr_valid && $stable(wr_data)));

    p_no_dual_pull_r9: assert property (@(posedge clk) disable iff (rst)
        scl_pull_o |-> !sda_pull_o);

    p_ptr_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        ptr_load |=> !ptr_load);
endmodule

bind lcd_cmd_rx lcd_rx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .scl_s      (scl_s),
    .sda_pull_o (sda_pull_o),
    .scl_pull_o (scl_pull_o),
    .wr_valid   (wr_valid),
    .wr_accept  (wr_accept),
    .wr_data    (wr_data),
    .ptr_load   (ptr_load)
);

// File: tb/sim_lcd_cmd_rx.sv
module sim_lcd_cmd_rx;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic addr_sel = 1'b1;
    logic [2:0] hw_sub = 3'd3;
    logic wr_accept = 1'b0;

    logic sda_pull_o, scl_pull_o, low_power, display_on, bias_half;
    logic [1:0] drive_mode, blink_rate;
    logic [2:0] sub_counter;
    logic bank_in, bank_out, blink_alt, ptr_load, wr_valid, wr_mine;
    logic [5:0] ptr_value;
    logic [7:0] wr_data;

    wire scl_line = m_scl & ~scl_pull_o;
    wire sda_line = m_sda & ~sda_pull_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_cmd_rx u0 (
        .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
        .addr_sel(addr_sel), .hw_sub(hw_sub), .wr_accept(wr_accept),
        .sda_pull_o(sda_pull_o), .scl_pull_o(scl_pull_o),
        .low_power(low_power), .display_on(display_on), .bias_half(bias_half),
        .drive_mode(drive_mode), .sub_counter(sub_counter),
        .bank_in(bank_in), .bank_out(bank_out), .blink_alt(blink_alt),
        .blink_rate(blink_rate), .ptr_load(ptr_load), .ptr_value(ptr_value),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_mine(wr_mine)
    );

    int checks = 0;
    int failures = 0;
    int accept_delay = 0;
    int received = 0;
    int pushed = 0;
    int ptr_seen = 0;
    logic [5:0] ptr_last = '0;
    int stretch_cycles = 0;
    int r12_viol = 0;
    logic prev_scl = 1'b1;
    logic prev_pull = 1'b0;
    logic [8:0] exp_q[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        while (scl_line !== 1'b1) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_q();
        m_scl = 1'b1; wait_q();
        m_sda = 1'b0; wait_q();
        m_scl = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_q();
        m_scl = 1'b1; wait_q();
        m_sda = 1'b1; wait_q();
    endtask

    task automatic write_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wait_q();
            m_scl = 1'b1; wait_scl_high(); wait_q();
            m_scl = 1'b0; wait_q();
        end
        m_sda = 1'b1; wait_q();
        m_scl = 1'b1; wait_scl_high();
        repeat (Q/2) @(negedge clk);
        ack = !sda_line;
        repeat (Q/2) @(negedge clk);
        m_scl = 1'b0; wait_q();
    endtask

    // Scoreboard driver: expected display byte goes into the queue first.
    task automatic send_data(input logic [7:0] b, input bit exp_mine, output bit ack);
        exp_q.push_back({exp_mine, b});
        pushed++;
        write_byte(b, ack);
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (wr_valid) begin
                repeat (accept_delay) @(negedge clk);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected display byte", int'(wr_data), 0);
                end else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    check(wr_data == e[7:0], "R9 display byte order/value", int'(wr_data), int'(e[7:0]));
                    check(wr_mine == e[8], "R8 subaddress match flag", int'(wr_mine), int'(e[8]));
                end
                received++;
                wr_accept = 1'b1;
                @(negedge clk);
                wr_accept = 1'b0;
            end
        end
    end

    always @(negedge clk) begin
        if (ptr_load) begin
            ptr_seen++;
            ptr_last = ptr_value;
        end
        if (scl_pull_o) stretch_cycles++;
        if (!rst && scl_line && prev_scl && (sda_pull_o != prev_pull)) r12_viol++;
        prev_scl  = scl_line;
        prev_pull = sda_pull_o;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit ack;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R11: reset values
        check(drive_mode == 2'b11, "R11 drive_mode reset", drive_mode, 3);
        check({low_power, display_on, bias_half} == 3'b000, "R11 mode bits reset",
              {low_power, display_on, bias_half}, 0);
        check({blink_alt, blink_rate, bank_in, bank_out, sub_counter} == '0,
              "R11 blink/bank/sub reset", {blink_alt, blink_rate, bank_in, bank_out, sub_counter}, 0);
        check({sda_pull_o, scl_pull_o, wr_valid} == 3'b000, "R11 no pulls reset",
              {sda_pull_o, scl_pull_o, wr_valid}, 0);

        // R1: wrong select bit -> whole transfer ignored
        bus_start();
        write_byte(8'h70, ack);
        check(ack == 1'b0, "R1 foreign address not acked", ack, 0);
        write_byte(8'hDD, ack);
        check(ack == 1'b0, "R1 ignored transfer byte not acked", ack, 0);
        check(drive_mode == 2'b11 && !display_on, "R1 ignored command not applied",
              {display_on, drive_mode}, 3);
        bus_stop();

        // R1: read direction not acknowledged
        bus_start();
        write_byte(8'h73, ack);
        check(ack == 1'b0, "R1 read address not acked", ack, 0);
        bus_stop();

        // R1/R2/R3..R7: command chain
        bus_start();
        write_byte(8'h72, ack);
        check(ack == 1'b1, "R1 matching address acked", ack, 1);
        write_byte(8'hDD, ack);
        check(ack == 1'b1, "R2 command byte acked", ack, 1);
        check({low_power, display_on, bias_half, drive_mode} == 5'b11101, "R3 mode-set fields",
              {low_power, display_on, bias_half, drive_mode}, 5'b11101);
        write_byte(8'hE3, ack);
        check(sub_counter == 3'd3, "R5 device-select", sub_counter, 3);
        write_byte(8'hFA, ack);
        check(bank_in == 1'b1 && bank_out == 1'b0, "R6 bank-select", {bank_in, bank_out}, 2'b10);
        write_byte(8'hF6, ack);
        check(blink_alt == 1'b1 && blink_rate == 2'd2, "R7 blink-select", {blink_alt, blink_rate}, 3'b110);
        write_byte(8'h27, ack);
        check(ptr_seen == 1 && ptr_last == 6'd39, "R4 pointer load pulse", ptr_last, 39);

        // R2/R8: data after last command, matching subaddress
        send_data(8'h55, 1'b1, ack);
        check(ack == 1'b1, "R8 matching display byte acked", ack, 1);
        send_data(8'hC1, 1'b1, ack);
        check(ack == 1'b1, "R2 command-like byte taken as data", ack, 1);
        check(drive_mode == 2'b01 && !blink_alt == 1'b0, "R2 command-like data not decoded",
              drive_mode, 1);
        check(ptr_seen == 1, "R4 no extra pointer pulse", ptr_seen, 1);
        bus_stop();

        // R8: subaddress mismatch -> no ack but forwarded
        bus_start();
        write_byte(8'h72, ack);
        write_byte(8'h65, ack);
        check(sub_counter == 3'd5, "R5 device-select second value", sub_counter, 5);
        send_data(8'h3C, 1'b0, ack);
        check(ack == 1'b0, "R8 foreign display byte not acked", ack, 0);
        bus_stop();

        // R9: stretch while writer is slow
        repeat (20) @(negedge clk);
        accept_delay = 700;
        stretch_cycles = 0;
        bus_start();
        write_byte(8'h72, ack);
        write_byte(8'h63, ack);
        send_data(8'hA1, 1'b1, ack);
        send_data(8'hB2, 1'b1, ack);
        check(ack == 1'b1, "R9 stretched byte acked", ack, 1);
        send_data(8'hC3, 1'b1, ack);
        check(stretch_cycles > 0, "R9 SCL held low while pending", stretch_cycles, 1);

        // R10: repeated start mid-transfer restarts address phase
        bus_start();
        write_byte(8'h72, ack);
        check(ack == 1'b1, "R10 address after repeated start acked", ack, 1);
        write_byte(8'h42, ack);
        check(drive_mode == 2'b10 && !display_on && !low_power, "R10 command after repeated start",
              {low_power, display_on, drive_mode}, 2);
        bus_stop();
        repeat (2000) @(negedge clk);

        // R10: bits after STOP without START are ignored
        write_byte(8'h72, ack);
        check(ack == 1'b0, "R10 no ack after stop", ack, 0);
        m_scl = 1'b1; m_sda = 1'b1;
        repeat (50) @(negedge clk);

        check(exp_q.size() == 0 && received == pushed, "R9 no display byte lost", received, pushed);
        check(r12_viol == 0, "R12 SDA pull steady while SCL high", r12_viol, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule